// File: doc/BRIEF.md
# Running Priority Calculator with Non-Maskable Override

This block works out the running priority of one CPU interface of an interrupt controller. It reads three 32-bit active-priority bitmaps (Group 0, secure Group 1, non-secure Group 1) and two flags. Each flag marks a non-maskable interrupt as active in one of the Group 1 banks. From these it derives two results. The first is an 8-bit effective priority that the preemption logic compares against pending interrupts. The second is the 64-bit value that a read of the running-priority register returns.

Active non-maskable interrupts take precedence over anything the bitmaps say. The register view reports them in its two top bits. Which flag lands in which bit depends on the security state of the reading access and on whether a higher exception level exists. Non-secure reads with security enabled see the priority folded into the non-secure half of the range. Both outputs are registered, one clock after the inputs they reflect. The bitmaps are written and cleared by neighbouring logic.

Top module: `running_prio_unit`

## Requirements
- R1: With every bitmap zero and no non-maskable flag taken into account, the effective priority is 0xFF.
- R2: Otherwise, with no non-maskable flag taken into account, the effective priority is the index of the lowest set bit in the OR of the three bitmaps, shifted left by 3. With 5 implemented priority bits the minimum binary point is 2, so bit k gives priority 8·k.
- R3: An active secure Group 1 non-maskable flag forces the effective priority to 0x00, whatever the bitmaps and the non-secure flag hold.
- R4: An active non-secure Group 1 non-maskable flag, with the secure flag clear, forces the effective priority to 0x00 when the security-disable input is 1, and to 0x80 when it is 0.
- R5: The effective priority never depends on the access security state or the higher-level-present input. It never carries the indicator bits of R8 and R9.
- R6: For a read with the higher level present, a non-secure access and security-disable 0, register bits 7:0 are (2·p) mod 256 when the effective priority p is at least 0x80, and 0x00 otherwise. An idle p of 0xFF therefore reads 0xFE.
- R7: For every other read, register bits 7:0 equal the effective priority.
- R8: With the feature enabled, the higher level present and a non-secure access, register bit 63 equals the non-secure Group 1 flag and bit 62 is 0.
- R9: With the feature enabled, in every other case, register bit 63 equals the secure Group 1 flag and bit 62 equals the non-secure Group 1 flag.
- R10: Register bits 61:8 are always 0.
- R11: With the feature parameter NMI_EN set to 0, both flags are ignored: the priority comes from R1/R2 alone and bits 63:62 read 0.
- R12: Both outputs are registered. During reset they hold 0xFF (effective priority) and 0x0000_0000_0000_00FF (register value). After reset they reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| apr_g0_i | input | 32 | Group 0 active-priority bitmap |
| apr_g1s_i | input | 32 | Secure Group 1 active-priority bitmap |
| apr_g1ns_i | input | 32 | Non-secure Group 1 active-priority bitmap |
| nmi_g1s_i | input | 1 | Secure Group 1 non-maskable interrupt active |
| nmi_g1ns_i | input | 1 | Non-secure Group 1 non-maskable interrupt active |
| sec_access_i | input | 1 | Register access is secure (1) or non-secure (0) |
| el3_present_i | input | 1 | Higher exception level implemented |
| sec_disable_i | input | 1 | Security disabled in the controller |
| eff_prio_o | output | 8 | Effective running priority for preemption checks |
| rpr_val_o | output | 64 | Running-priority register read value |

## Verification
The assertions check on every cycle that an active flag forces the effective priority one cycle later, that the idle value follows an empty bitmap set, and that the top-bit mapping for non-secure reads holds. They also check that the bits between 8 and 61 stay zero, and that a build without the feature keeps the two top bits clear. Only the bench scenarios can show the correct lowest-bit selection across all three groups, including bit 0 and bit 31 and mixed groups. The same holds for the folding of the non-secure view at its 0x80 boundary and for the one-cycle latency. A second instance built without the feature is compared cycle by cycle with the same stimulus, which shows that the flags are ignored there.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_BITMAP = 2'd1,
    SRC_NMI_S  = 2'd2,
    SRC_NMI_NS = 2'd3
  } prio_src_e;

  localparam int          PRIO_W      = 8;
  localparam int          RPR_W       = 64;
  localparam int          RPR_TOP     = 63;
  localparam int          RPR_NEXT    = 62;
  localparam logic [7:0]  IDLE_PRIO   = 8'hFF;
  localparam logic [7:0]  NS_NMI_PRIO = 8'h80;
  localparam logic [7:0]  TOP_PRIO    = 8'h00;

  // Fold a priority into the non-secure half of the range.
  function automatic logic [7:0] ns_fold(input logic [7:0] p);
    return p[7] ? {p[6:0], 1'b0} : 8'h00;
  endfunction

endpackage

// File: rtl/rpc_apr_scan.sv
module rpc_apr_scan
  import rpc_pkg::*;
#(
  parameter int APR_W = 32,
  parameter int SHIFT = 3
) (
  input  logic [APR_W-1:0]  g0_i,
  input  logic [APR_W-1:0]  g1s_i,
  input  logic [APR_W-1:0]  g1ns_i,
  output logic              any_active_o,
  output logic [PRIO_W-1:0] bm_prio_o
);
  localparam int IDX_W = $clog2(APR_W);

  logic [APR_W-1:0] merged;
  logic [IDX_W-1:0] low_idx;

  // Index of the lowest set bit; scan from the top so the lowest wins.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [APR_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = APR_W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    merged       = g0_i | g1s_i | g1ns_i;
    any_active_o = |merged;
    low_idx      = lowest_set(merged);
    bm_prio_o    = any_active_o ? PRIO_W'(int'(low_idx) << SHIFT) : IDLE_PRIO;
  end

  // R2: a bitmap-derived priority sits on the binary-point grid
  always_comb begin
    if (any_active_o) begin
      assert_grid_R2: assert (bm_prio_o[SHIFT-1:0] == '0)
        else $error("bitmap priority off grid");
    end
  end

endmodule

// File: rtl/rpc_nmi_sel.sv
module rpc_nmi_sel
  import rpc_pkg::*;
#(
  parameter bit NMI_EN = 1'b1
) (
  input  logic [PRIO_W-1:0] bm_prio_i,
  input  logic              any_active_i,
  input  logic              nmi_s_i,
  input  logic              nmi_ns_i,
  input  logic              sec_disable_i,
  output logic [PRIO_W-1:0] eff_prio_o,
  output prio_src_e         src_o
);

  prio_src_e base_src;
  assign base_src = any_active_i ? SRC_BITMAP : SRC_IDLE;

  generate
    if (NMI_EN) begin : g_nmi
      always_comb begin
        if (nmi_s_i)       src_o = SRC_NMI_S;
        else if (nmi_ns_i) src_o = SRC_NMI_NS;
        else               src_o = base_src;
      end
    end else begin : g_plain
      assign src_o = base_src;
    end
  endgenerate

  always_comb begin
    unique case (src_o)
      SRC_NMI_S:  eff_prio_o = TOP_PRIO;
      SRC_NMI_NS: eff_prio_o = sec_disable_i ? TOP_PRIO : NS_NMI_PRIO;
      SRC_BITMAP: eff_prio_o = bm_prio_i;
      default:    eff_prio_o = IDLE_PRIO;
    endcase
  end

  // R11: with the feature off no flag may ever select the source
  always_comb begin
    if (!NMI_EN) begin
      assert_noflag_src_R11: assert (src_o == SRC_IDLE || src_o == SRC_BITMAP)
        else $error("flag source selected while feature disabled");
    end
    // R1: idle source only when no bitmap bit is set
    if (src_o == SRC_IDLE) begin
      assert_idle_src_R1: assert (!any_active_i)
        else $error("idle source with active bitmap");
    end
  end

endmodule

// File: rtl/rpc_rpr_fmt.sv
module rpc_rpr_fmt
  import rpc_pkg::*;
#(
  parameter bit NMI_EN = 1'b1
) (
  input  logic [PRIO_W-1:0] eff_prio_i,
  input  logic              sec_access_i,
  input  logic              el3_present_i,
  input  logic              sec_disable_i,
  input  logic              nmi_s_i,
  input  logic              nmi_ns_i,
  output logic              ns_view_o,
  output logic [RPR_W-1:0]  rpr_o
);

  logic              ns_access;
  logic [PRIO_W-1:0] low_byte;
  logic [1:0]        top_bits;

  assign ns_access = el3_present_i && !sec_access_i;
  assign ns_view_o = ns_access && !sec_disable_i;
  assign low_byte  = ns_view_o ? ns_fold(eff_prio_i) : eff_prio_i;

  generate
    if (NMI_EN) begin : g_ind
      // top_bits[1] -> bit 63, top_bits[0] -> bit 62
      assign top_bits = ns_access ? {nmi_ns_i, 1'b0} : {nmi_s_i, nmi_ns_i};
    end else begin : g_noind
      assign top_bits = 2'b00;
    end
  endgenerate

  always_comb begin
    rpr_o                     = '0;
    rpr_o[PRIO_W-1:0]         = low_byte;
    rpr_o[RPR_TOP:RPR_NEXT]   = top_bits;
  end

  // R6: the folded view never reports an odd priority
  always_comb begin
    if (ns_view_o) begin
      assert_fold_even_R6: assert (rpr_o[0] == 1'b0)
        else $error("odd value in non-secure view");
    end
  end

endmodule

// File: rtl/running_prio_unit.sv
module running_prio_unit
  import rpc_pkg::*;
#(
  parameter int PRIO_BITS = 5,
  parameter bit NMI_EN    = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [(1<<PRIO_BITS)-1:0]  apr_g0_i,
  input  logic [(1<<PRIO_BITS)-1:0]  apr_g1s_i,
  input  logic [(1<<PRIO_BITS)-1:0]  apr_g1ns_i,
  input  logic                       nmi_g1s_i,
  input  logic                       nmi_g1ns_i,
  input  logic                       sec_access_i,
  input  logic                       el3_present_i,
  input  logic                       sec_disable_i,
  output logic [7:0]                 eff_prio_o,
  output logic [63:0]                rpr_val_o
);
  localparam int APR_W   = 1 << PRIO_BITS;
  localparam int MIN_BPR = PRIO_W - PRIO_BITS - 1;
  localparam int SHIFT   = MIN_BPR + 1;

  logic              any_active;
  logic [PRIO_W-1:0] bm_prio;
  logic [PRIO_W-1:0] eff_next;
  prio_src_e         src;
  logic              ns_view;
  logic [RPR_W-1:0]  rpr_next;

  rpc_apr_scan #(.APR_W(APR_W), .SHIFT(SHIFT)) u_scan (
    .g0_i         (apr_g0_i),
    .g1s_i        (apr_g1s_i),
    .g1ns_i       (apr_g1ns_i),
    .any_active_o (any_active),
    .bm_prio_o    (bm_prio)
  );

  rpc_nmi_sel #(.NMI_EN(NMI_EN)) u_sel (
    .bm_prio_i     (bm_prio),
    .any_active_i  (any_active),
    .nmi_s_i       (nmi_g1s_i),
    .nmi_ns_i      (nmi_g1ns_i),
    .sec_disable_i (sec_disable_i),
    .eff_prio_o    (eff_next),
    .src_o         (src)
  );

  rpc_rpr_fmt #(.NMI_EN(NMI_EN)) u_fmt (
    .eff_prio_i    (eff_next),
    .sec_access_i  (sec_access_i),
    .el3_present_i (el3_present_i),
    .sec_disable_i (sec_disable_i),
    .nmi_s_i       (nmi_g1s_i),
    .nmi_ns_i      (nmi_g1ns_i),
    .ns_view_o     (ns_view),
    .rpr_o         (rpr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_prio_o <= IDLE_PRIO;
      rpr_val_o  <= {{(RPR_W-PRIO_W){1'b0}}, IDLE_PRIO};
    end else begin
      eff_prio_o <= eff_next;
      rpr_val_o  <= rpr_next;
    end
  end

  // R1: nothing active -> idle value next cycle
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((apr_g0_i | apr_g1s_i | apr_g1ns_i) == '0 && !(NMI_EN && (nmi_g1s_i || nmi_g1ns_i)))
      |=> eff_prio_o == 8'hFF);

  // R3: secure flag forces top priority
  assert_nmi_secure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (NMI_EN && nmi_g1s_i) |=> eff_prio_o == 8'h00);

  // R4: non-secure flag alone depends on security-disable
  assert_nmi_nonsecure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (NMI_EN && !nmi_g1s_i && nmi_g1ns_i)
      |=> eff_prio_o == ($past(sec_disable_i) ? 8'h00 : 8'h80));

  // R8: non-secure access with higher level present
  assert_top_ns_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (NMI_EN && el3_present_i && !sec_access_i)
      |=> (rpr_val_o[63] == $past(nmi_g1ns_i)) && !rpr_val_o[62]);

  // R10: middle bits stay clear
  assert_mid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rpr_val_o[61:8] == '0);

  generate
    if (!NMI_EN) begin : g_off_chk
      // R11: indicator bits clear without the feature
      assert_no_ind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rpr_val_o[63:62] == 2'b00);
    end
  endgenerate

endmodule

// File: tb/running_prio_unit_test.sv
`timescale 1ns/1ps
module running_prio_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] g0 = '0, g1s = '0, g1ns = '0;
  logic        fs = 1'b0, fns = 1'b0, sec = 1'b0, el3 = 1'b0, ds = 1'b0;
  logic [7:0]  eff_a, eff_b;
  logic [63:0] rpr_a, rpr_b;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  running_prio_unit #(.PRIO_BITS(5), .NMI_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .apr_g0_i(g0), .apr_g1s_i(g1s), .apr_g1ns_i(g1ns),
    .nmi_g1s_i(fs), .nmi_g1ns_i(fns), .sec_access_i(sec), .el3_present_i(el3),
    .sec_disable_i(ds), .eff_prio_o(eff_a), .rpr_val_o(rpr_a));

  running_prio_unit #(.PRIO_BITS(5), .NMI_EN(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .apr_g0_i(g0), .apr_g1s_i(g1s), .apr_g1ns_i(g1ns),
    .nmi_g1s_i(fs), .nmi_g1ns_i(fns), .sec_access_i(sec), .el3_present_i(el3),
    .sec_disable_i(ds), .eff_prio_o(eff_b), .rpr_val_o(rpr_b));

  // Reference: effective priority from the requirements
  function automatic int ref_eff(bit en);
    logic [31:0] all;
    if (en && fs) return 0;                    // R3
    if (en && fns) return ds ? 0 : 128;        // R4
    all = g0 | g1s | g1ns;
    if (all == 0) return 255;                  // R1
    for (int k = 0; k < 32; k++) if (all[k]) return k * 8;  // R2
    return -1;
  endfunction

  function automatic logic [63:0] ref_rpr(bit en);
    int p;
    logic [63:0] r;
    p = ref_eff(en);
    if (el3 && !sec && !ds) p = (p >= 128) ? (p * 2) % 256 : 0;  // R6 / R7
    r = 64'(p);
    if (en) begin
      if (el3 && !sec) r[63] = fns;            // R8
      else begin r[63] = fs; r[62] = fns; end  // R9
    end
    return r;
  endfunction

  function automatic string eff_tag(bit en);
    if (!en) return "R11";
    if (fs) return "R3";
    if (fns) return "R4";
    return ((g0 | g1s | g1ns) == 0) ? "R1" : "R2";
  endfunction

  function automatic string rpr_tag(bit en, logic [63:0] got, logic [63:0] exp);
    if (got[63:62] != exp[63:62]) return !en ? "R11" : (el3 && !sec) ? "R8" : "R9";
    if (got[61:8] != exp[61:8]) return "R10";
    return (el3 && !sec && !ds) ? "R6" : "R7";
  endfunction

  task automatic cmp_eff(string tag, string note, logic [7:0] got, int exp);
    compared++;
    if (int'(got) != exp) begin
      mismatched++;
      $display("FAIL %s %s eff: got %02h expected %02h", tag, note, got, exp[7:0]);
    end
  endtask

  task automatic cmp_rpr(string tag, string note, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s rpr: got %016h expected %016h", tag, note, got, exp);
    end
  endtask

  // Apply inputs after a falling edge, compare at the next falling edge
  // (one register between inputs and outputs, R12).
  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input logic s_f, input logic ns_f, input logic s_acc,
                      input logic hi_lvl, input logic dis, input string note);
    int          ea, eb;
    logic [63:0] ra, rb;
    string       ta, tb, qa, qb;
    g0 = a; g1s = b; g1ns = c; fs = s_f; fns = ns_f; sec = s_acc; el3 = hi_lvl; ds = dis;
    ea = ref_eff(1'b1); eb = ref_eff(1'b0);
    ra = ref_rpr(1'b1); rb = ref_rpr(1'b0);
    ta = eff_tag(1'b1); tb = eff_tag(1'b0);
    @(negedge clk);
    qa = rpr_tag(1'b1, rpr_a, ra); qb = rpr_tag(1'b0, rpr_b, rb);
    cmp_eff(ta, note, eff_a, ea);
    cmp_rpr(qa, note, rpr_a, ra);
    cmp_eff(tb, note, eff_b, eb);
    cmp_rpr(qb, note, rpr_b, rb);
  endtask

  task automatic all_views(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                           input logic s_f, input logic ns_f, input string note);
    for (int v = 0; v < 8; v++)
      step(a, b, c, s_f, ns_f, v[0], v[1], v[2], note);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R12: reset state, with busy inputs that must not leak through
    g0 = 32'h10; fs = 1'b1; fns = 1'b1; el3 = 1'b1;
    repeat (3) @(negedge clk);
    cmp_eff("R12", "reset", eff_a, 255);
    cmp_rpr("R12", "reset", rpr_a, 64'hFF);
    cmp_eff("R12", "reset", eff_b, 255);
    cmp_rpr("R12", "reset", rpr_b, 64'hFF);
    rst_n = 1'b1;

    // R1 idle under every access view (R6: idle folds to FE)
    all_views('0, '0, '0, 1'b0, 1'b0, "idle");
    // R2 single bits at the edges of each group
    all_views(32'h1, '0, '0, 1'b0, 1'b0, "g0 bit0");
    all_views('0, 32'h8000_0000, '0, 1'b0, 1'b0, "g1s bit31");
    all_views('0, '0, 32'h0001_0000, 1'b0, 1'b0, "g1ns bit16 boundary 0x80");
    all_views('0, '0, 32'h0000_8000, 1'b0, 1'b0, "g1ns bit15 just below 0x80");
    all_views(32'hF000_0000, 32'h0400_0000, 32'h0002_0000, 1'b0, 1'b0, "mixed groups");
    // R3 / R4 flag overrides and top-bit mapping R8 / R9
    all_views(32'h4, '0, '0, 1'b1, 1'b0, "secure flag");
    all_views('0, '0, '0, 1'b0, 1'b1, "non-secure flag");
    all_views(32'h8000_0000, 32'h2, '0, 1'b1, 1'b1, "both flags");
    // R5: effective priority constant while only access inputs change
    for (int v = 0; v < 4; v++)
      step(32'h40, '0, '0, 1'b0, 1'b0, v[0], v[1], 1'b0, "R5 access-independence");
    // R12 latency: back-to-back changes each seen exactly one cycle later
    for (int k = 0; k < 32; k++)
      step(32'(1) << k, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R12 latency walk");
    // Random sweep; AND of words keeps bitmaps sparse
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb, rc;
      logic [7:0]  ctl;
      ra = $urandom() & $urandom() & $urandom();
      rb = $urandom() & $urandom() & $urandom();
      rc = $urandom() & $urandom() & $urandom();
      ctl = 8'($urandom());
      if (ctl[7]) begin ra = '0; rb = '0; rc = '0; end
      step(ra, rb, rc, ctl[0] & ctl[1], ctl[2] & ctl[3], ctl[4], ctl[5], ctl[6], "random");
    end
    summary();
    $finish;
  end

endmodule